// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the sixteen 32-bit architectural registers of a processor core that runs in several privilege modes. Some logical indices share one physical register across all modes. Others are backed by a private copy that is chosen by the mode now in force. Because of this, an exception handler can use its own stack and link registers, and in fast-interrupt mode a larger scratch set, without saving the interrupted context first.

The block also keeps the current status word (only its mode field is written here) and one saved-status register for each exception mode. Two combinational read ports and one write port address registers by logical index. A saved-status port always works on the register that belongs to the current mode. A separate path loads and shows the program counter. Instruction decode, arithmetic and exception-entry sequencing are done outside the block.

Top module: `bankreg_file`

## Requirements
- R1: While reset is low, and after it is released, every register in every bank, the program counter, the status output and every saved-status register read zero. Status mode field 0 is handled as user mode.
- R2: A mode write stores `mode_wdata | 5'h10` into status bits [4:0]. The new value appears on `status_o` after the next rising edge. Mode codes (low four bits) are: user 0x0, fast-interrupt 0x1, interrupt 0x2, supervisor 0x3, abort 0x7, undefined 0xB, system 0xF.
- R3: Logical registers 0 to 7 are a single set shared by every mode.
- R4: Logical registers 8 to 12 use a private bank in fast-interrupt mode. In every other mode they use the common user bank.
- R5: Logical registers 13 and 14 have a private copy in each of fast-interrupt, interrupt, supervisor, abort and undefined mode. User and system mode share the user copy.
- R6: Each of the five exception modes has its own saved-status register on the saved-status port. In user or system mode a saved-status read returns the current status word, and a saved-status write has no effect.
- R7: When a register write and a mode write happen in the same cycle, the register write goes to the bank of the mode that was active before the change.
- R8: Both read ports are combinational and independent of each other. A write becomes visible on the read ports only after the next rising edge.
- R9: Logical index 15 is the program counter and is the same in every mode. It reads through either read port, is loaded by `pc_we`, and is also loaded by the write port at index 15. If both load it in the same cycle, `pc_we` wins.
- R10: A mode code not in the list of R2 is still stored as in R2, but it selects user-mode banking and has no saved-status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode write strobe |
| mode_wdata | input | 5 | New mode code |
| status_o | output | 32 | Current status word (mode field in [4:0]) |
| rd_a_idx | input | 4 | Read port A logical index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B logical index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write logical index |
| wr_data | input | 32 | Register write data |
| spsr_we | input | 1 | Saved-status write enable |
| spsr_wdata | input | 32 | Saved-status write data |
| spsr_rdata | output | 32 | Saved-status read data for the current mode |
| pc_we | input | 1 | Program-counter load strobe |
| pc_wdata | input | 32 | Program-counter load value |
| pc_o | output | 32 | Program counter |

## Verification
Read data and the saved-status read are combinational, so they are due in the same cycle as the index or mode that selects them. Register, program-counter, saved-status and mode writes are due one rising edge after the strobe. The bench drives every stimulus just after a falling edge and compares results at the following falling edge. Same-cycle checks, such as the old value still showing while a write is pending, are sampled 1 ns after the inputs change and before the edge that commits them.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int DATA_W   = 32;
  localparam int IDX_W    = 4;
  localparam int MODE_W   = 5;
  localparam int SHARED_N = 8;   // logical 0..7
  localparam int HIGH_N   = 5;   // logical 8..12
  localparam int SL_N     = 2;   // logical 13, 14
  localparam int EXC_N    = 4;   // irq, svc, abt, und (stack/link only)
  localparam int SPSR_N   = 5;   // exception modes owning a saved status

  localparam int USR_BASE = SHARED_N;
  localparam int FIQ_BASE = USR_BASE + HIGH_N + SL_N;
  localparam int EXC_BASE = FIQ_BASE + HIGH_N + SL_N;
  localparam int NPHYS    = EXC_BASE + EXC_N * SL_N;
  localparam int PHYS_W   = $clog2(NPHYS);

  localparam logic [3:0] MC_USR = 4'h0;
  localparam logic [3:0] MC_FIQ = 4'h1;
  localparam logic [3:0] MC_IRQ = 4'h2;
  localparam logic [3:0] MC_SVC = 4'h3;
  localparam logic [3:0] MC_ABT = 4'h7;
  localparam logic [3:0] MC_UND = 4'hB;
  localparam logic [3:0] MC_SYS = 4'hF;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  function automatic bank_e decode_bank(input logic [3:0] code);
    case (code)
      MC_FIQ:  decode_bank = BK_FIQ;
      MC_IRQ:  decode_bank = BK_IRQ;
      MC_SVC:  decode_bank = BK_SVC;
      MC_ABT:  decode_bank = BK_ABT;
      MC_UND:  decode_bank = BK_UND;
      default: decode_bank = BK_USR;   // user, system and unlisted codes
    endcase
  endfunction

endpackage

// File: rtl/bankreg_map.sv
module bankreg_map
  import bankreg_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  bank_e             bank,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);

  always_comb begin
    is_pc = (idx == 4'd15);
    phys  = '0;
    if (int'(idx) < SHARED_N) begin
      phys = PHYS_W'(int'(idx));
    end else if (int'(idx) < SHARED_N + HIGH_N) begin
      if (bank == BK_FIQ) phys = PHYS_W'(FIQ_BASE + int'(idx) - SHARED_N);
      else                phys = PHYS_W'(USR_BASE + int'(idx) - SHARED_N);
    end else if (!is_pc) begin
      case (bank)
        BK_USR:  phys = PHYS_W'(USR_BASE + HIGH_N + int'(idx) - 13);
        BK_FIQ:  phys = PHYS_W'(FIQ_BASE + HIGH_N + int'(idx) - 13);
        default: phys = PHYS_W'(EXC_BASE + SL_N * (int'(bank) - int'(BK_IRQ))
                                + int'(idx) - 13);
      endcase
    end
  end

endmodule

// File: rtl/bankreg_store.sv
module bankreg_store
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PHYS_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PHYS_W-1:0] raddr_a,
  input  logic [PHYS_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] regs_q [NPHYS];
  logic [DATA_W-1:0] regs_d [NPHYS];

  always_comb begin
    for (int i = 0; i < NPHYS; i++) begin
      regs_d[i] = (we && (int'(waddr) == i)) ? wdata : regs_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs_q[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NPHYS; i++) regs_q[i] <= regs_d[i];
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/bankreg_spsr.sv
module bankreg_spsr
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] saved [SPSR_N];

  for (genvar g = 0; g < SPSR_N; g++) begin : g_bank
    logic              en;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    assign en = we && (int'(bank) == g + 1);

    always_comb begin
      d = en ? wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign saved[g] = q;
  end

  always_comb begin
    if (bank == BK_USR) rdata = status;
    else                rdata = saved[int'(bank) - 1];
  end

endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [4:0]        mode_wdata,
  output logic [31:0]       status_o,
  input  logic [3:0]        rd_a_idx,
  output logic [31:0]       rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [31:0]       rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [31:0]       wr_data,
  input  logic              spsr_we,
  input  logic [31:0]       spsr_wdata,
  output logic [31:0]       spsr_rdata,
  input  logic              pc_we,
  input  logic [31:0]       pc_wdata,
  output logic [31:0]       pc_o
);

  logic [MODE_W-1:0] mode_q, mode_d;
  logic [DATA_W-1:0] pc_q, pc_d;
  logic              pc_en;
  bank_e             bank;

  logic [PHYS_W-1:0] ph_a, ph_b, ph_w;
  logic              pc_a, pc_b, pc_w;
  logic [DATA_W-1:0] st_a, st_b;

  assign bank = decode_bank(mode_q[3:0]);

  bankreg_map u_map_a (.idx(rd_a_idx), .bank(bank), .phys(ph_a), .is_pc(pc_a));
  bankreg_map u_map_b (.idx(rd_b_idx), .bank(bank), .phys(ph_b), .is_pc(pc_b));
  bankreg_map u_map_w (.idx(wr_idx),   .bank(bank), .phys(ph_w), .is_pc(pc_w));

  bankreg_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en && !pc_w),
    .waddr   (ph_w),
    .wdata   (wr_data),
    .raddr_a (ph_a),
    .raddr_b (ph_b),
    .rdata_a (st_a),
    .rdata_b (st_b)
  );

  bankreg_spsr u_spsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .bank   (bank),
    .we     (spsr_we),
    .wdata  (spsr_wdata),
    .status (status_o),
    .rdata  (spsr_rdata)
  );

  // next-state
  always_comb begin
    mode_d = mode_wdata | 5'h10;
    pc_en  = pc_we || (wr_en && pc_w);
    pc_d   = pc_we ? pc_wdata : wr_data;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign status_o  = {{(DATA_W-MODE_W){1'b0}}, mode_q};
  assign pc_o      = pc_q;
  assign rd_a_data = pc_a ? pc_q : st_a;
  assign rd_b_data = pc_b ? pc_q : st_b;

endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_we,
  input logic [4:0]  mode_wdata,
  input logic [31:0] status_o,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [31:0] spsr_rdata,
  input logic        pc_we,
  input logic [31:0] pc_wdata,
  input logic [31:0] pc_o
);

  logic seen_q = 1'b0;
  always_ff @(posedge clk) seen_q <= 1'b1;

  logic user_like;
  always_comb begin
    case (status_o[3:0])
      4'h1, 4'h2, 4'h3, 4'h7, 4'hB: user_like = 1'b0;
      default:                      user_like = 1'b1;
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    (seen_q && !rst_n) |-> (pc_o == 32'h0 && status_o == 32'h0));

  assert_mode_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (status_o[4:0] == ($past(mode_wdata) | 5'h10)));

  assert_shared_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < 4'd8) |=>
      (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

  assert_spsr_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    user_like |-> (spsr_rdata == status_o));

  assert_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !pc_we && !mode_we) |=>
      (!$stable(rd_a_idx) || $stable(rd_a_data)));

  assert_pc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (pc_o == $past(pc_wdata)));

endmodule

bind bankreg_file bankreg_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_we    (mode_we),
  .mode_wdata (mode_wdata),
  .status_o   (status_o),
  .rd_a_idx   (rd_a_idx),
  .rd_a_data  (rd_a_data),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .spsr_rdata (spsr_rdata),
  .pc_we      (pc_we),
  .pc_wdata   (pc_wdata),
  .pc_o       (pc_o)
);

// File: tb/test_bankreg_file.sv
`timescale 1ns/1ps
module test_bankreg_file;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [4:0]  mode_wdata = '0;
  logic [31:0] status_o;
  logic [3:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [3:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        spsr_we = 1'b0;
  logic [31:0] spsr_wdata = '0;
  logic [31:0] spsr_rdata;
  logic        pc_we = 1'b0;
  logic [31:0] pc_wdata = '0;
  logic [31:0] pc_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  bankreg_file i_bankreg_file (.*);

  // user, fiq, irq, svc, abt, und
  logic [4:0] codes [6] = '{5'h00, 5'h01, 5'h02, 5'h03, 5'h07, 5'h0B};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m);
    @(negedge clk); mode_we = 1'b1; mode_wdata = m;
    @(negedge clk); mode_we = 1'b0;
    chk("R2 mode field", status_o, {27'b0, m | 5'h10});
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic spsr_wr(input logic [31:0] d);
    @(negedge clk); spsr_we = 1'b1; spsr_wdata = d;
    @(negedge clk); spsr_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string req);
    rd_a_idx = idx; #1;
    chk(req, rd_a_data, exp);
  endtask

  task automatic test_reset();
    chk("R1 status", status_o, 32'h0);
    chk("R1 pc", pc_o, 32'h0);
    chk("R1 spsr in reset mode", spsr_rdata, 32'h0);
    for (int i = 0; i < 16; i++) rd(i[3:0], 32'h0, "R1 user bank");
    for (int m = 1; m < 6; m++) begin
      set_mode(codes[m]);
      for (int i = 8; i < 15; i++) rd(i[3:0], 32'h0, "R1 banked");
      chk("R1 spsr", spsr_rdata, 32'h0);
    end
    set_mode(5'h00);
  endtask

  task automatic test_shared();
    wr(4'd3, 32'h3333_0003);
    set_mode(5'h01);
    rd(4'd3, 32'h3333_0003, "R3 r3 seen in fiq");
    set_mode(5'h03);
    wr(4'd5, 32'h5555_0005);
    set_mode(5'h00);
    rd(4'd5, 32'h5555_0005, "R3 r5 seen in user");
  endtask

  task automatic test_fiq_bank();
    for (int i = 8; i < 13; i++) wr(i[3:0], 32'h0800_0000 + i);
    set_mode(5'h01);
    for (int i = 8; i < 13; i++) rd(i[3:0], 32'h0, "R4 fiq bank private");
    for (int i = 8; i < 13; i++) wr(i[3:0], 32'hF800_0000 + i);
    set_mode(5'h02);
    for (int i = 8; i < 13; i++) rd(i[3:0], 32'h0800_0000 + i, "R4 irq uses user bank");
    set_mode(5'h01);
    rd(4'd12, 32'hF800_000C, "R4 fiq bank kept");
  endtask

  task automatic test_stack_link();
    for (int m = 0; m < 6; m++) begin
      set_mode(codes[m]);
      wr(4'd13, 32'h1300_0000 + m);
      wr(4'd14, 32'h1400_0000 + m);
    end
    set_mode(5'h0F);
    rd(4'd13, 32'h1300_0000, "R5 system shares user sp");
    rd(4'd14, 32'h1400_0000, "R5 system shares user lr");
    for (int m = 0; m < 6; m++) begin
      set_mode(codes[m]);
      rd(4'd13, 32'h1300_0000 + m, "R5 sp per mode");
      rd(4'd14, 32'h1400_0000 + m, "R5 lr per mode");
    end
  endtask

  task automatic test_spsr();
    for (int m = 1; m < 6; m++) begin
      set_mode(codes[m]);
      spsr_wr(32'h5000_0000 + m);
    end
    for (int m = 1; m < 6; m++) begin
      set_mode(codes[m]);
      chk("R6 spsr per mode", spsr_rdata, 32'h5000_0000 + m);
    end
    set_mode(5'h00);
    spsr_wr(32'hDEAD_BEEF);
    chk("R6 user spsr reads status", spsr_rdata, 32'h0000_0010);
    set_mode(5'h0F);
    spsr_wr(32'hCAFE_0000);
    chk("R6 system spsr reads status", spsr_rdata, 32'h0000_001F);
    set_mode(5'h03);
    chk("R6 svc spsr untouched", spsr_rdata, 32'h5000_0003);
    set_mode(5'h0B);
    chk("R6 und spsr untouched", spsr_rdata, 32'h5000_0005);
  endtask

  task automatic test_same_cycle();
    set_mode(5'h00);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = 5'h02;
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h7777_7777;
    @(negedge clk);
    mode_we = 1'b0; wr_en = 1'b0;
    chk("R7 now in irq", status_o, 32'h12);
    rd(4'd13, 32'h1300_0002, "R7 irq sp not written");
    set_mode(5'h00);
    rd(4'd13, 32'h7777_7777, "R7 write went to old mode");
  endtask

  task automatic test_ports();
    set_mode(5'h00);
    wr(4'd2, 32'h2222_2222);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd2; wr_data = 32'hAAAA_AAAA;
    rd_a_idx = 4'd2; rd_b_idx = 4'd3; #1;
    chk("R8 old value before edge", rd_a_data, 32'h2222_2222);
    chk("R8 port b independent", rd_b_data, 32'h3333_0003);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R8 new value after edge", rd_a_data, 32'hAAAA_AAAA);
    chk("R8 port b unchanged", rd_b_data, 32'h3333_0003);
  endtask

  task automatic test_pc();
    @(negedge clk); pc_we = 1'b1; pc_wdata = 32'h0000_0100;
    @(negedge clk); pc_we = 1'b0;
    chk("R9 pc load", pc_o, 32'h0000_0100);
    rd_b_idx = 4'd15; #1;
    chk("R9 index 15 reads pc", rd_b_data, 32'h0000_0100);
    wr(4'd15, 32'h0000_0200);
    chk("R9 write port loads pc", pc_o, 32'h0000_0200);
    @(negedge clk);
    pc_we = 1'b1; pc_wdata = 32'h0000_0300;
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_0400;
    @(negedge clk);
    pc_we = 1'b0; wr_en = 1'b0;
    chk("R9 pc_we priority", pc_o, 32'h0000_0300);
    set_mode(5'h01);
    rd(4'd15, 32'h0000_0300, "R9 pc shared in fiq");
  endtask

  task automatic test_unknown();
    set_mode(5'h04);
    chk("R10 status of unlisted code", status_o, 32'h14);
    rd(4'd13, 32'h7777_7777, "R10 user sp");
    rd(4'd8, 32'h0800_0008, "R10 user r8");
    spsr_wr(32'h1234_5678);
    chk("R10 no spsr", spsr_rdata, 32'h14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd_a_idx = 4'd0; #1;
    chk("R1 read during reset", rd_a_data, 32'h0);
    chk("R1 pc during reset", pc_o, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_shared();
    test_fiq_bank();
    test_stack_link();
    test_spsr();
    test_same_cycle();
    test_ports();
    test_pc();
    test_unknown();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule